// File: doc/BRIEF.md
# Translation Fault Capture Register Block

This block holds the software-visible registers of an I/O address translation unit that concern configuration and error reporting. A simple word-indexed bus port reads and writes a small register file. A separate fault port receives a one-cycle notification from the translation logic whenever a translation fails. The notification carries the offending address and a flag that says whether the failed access was a read.

When a fault arrives, the block latches the address and marks read faults in a status word. It then raises a level interrupt that stays high until software touches either fault register. A read or a write of either one clears it. The status word always carries a fixed pattern of reserved bits, both after reset and after every write.

Register indices are word offsets, which are byte offsets shifted right by two. Index 0 is control, 1 is arbiter enable, 2 is page flush, 3 is fault status and 4 is fault address. All other indices are plain storage words. The bus reset input is asynchronous and active low. The block synchronises the release of reset internally, so registers leave reset on the second rising clock edge after `rst_n` goes high.

Top module: `xlat_fault_regs`

## Requirements
- R1: In reset, and after it, control (index 0) reads 0x0400_0000 (VERSION), arbiter enable (index 1) reads 0x0000_001F (MASTER_ID) and fault status (index 3) reads 0x0000_0F00 (RESV_BITS). The interrupt is low and `rdata` is zero.
- R2: A read strobe returns the addressed word on `rdata` one cycle later, and `rdata` holds that value until the next read strobe. A word written at any index other than 2 and 3 reads back exactly as written. A read and a write of the same index in one cycle return the old value.
- R3: A write to index 2 stores the written value ANDed with 0xFFFF_F000 (FLUSH_MASK).
- R4: A write to index 3 stores (value AND 0x0000_00FF) OR 0x0000_0F00, so the reserved bits are always set.
- R5: A fault pulse stores `flt_addr` in index 4 and sets `err_irq` on the next cycle. If a bus write to index 4 happens in the same cycle, the fault address wins.
- R6: A fault with `flt_is_read` high sets bit 7 of the status word. A fault with `flt_is_read` low leaves bit 7 as it was. A status write in the same cycle is applied first, and the read bit is then ORed in.
- R7: A bus read of index 3 or index 4 clears `err_irq` on the next cycle.
- R8: A bus write of index 3 or index 4 clears `err_irq` on the next cycle.
- R9: When a fault and a clearing access fall in the same cycle, `err_irq` is high afterwards.
- R10: Accesses to any index other than 3 and 4, and idle cycles, leave `err_irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| idx | input | 6 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| flt_valid | input | 1 | One-cycle fault notification |
| flt_addr | input | 32 | Faulting address |
| flt_is_read | input | 1 | High when the faulting access was a read |
| err_irq | output | 1 | Level error interrupt |

## Verification
The hardest case to reach is a fault arriving in the same cycle as a clearing access to a fault register. The same applies to a read fault landing on a status write. Both need the fault port and the bus port driven together on one edge. Directed steps place a fault next to a read of index 4, a write of index 3 and a write of index 4. A long random phase then biases indices toward 0 to 7 and raises faults often, so these collisions recur with varied data. A per-cycle model compares `rdata` and `err_irq` throughout.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_ARB   = 1;
  localparam int unsigned IDX_FLUSH = 2;
  localparam int unsigned IDX_STAT  = 3;
  localparam int unsigned IDX_ADDR  = 4;
endpackage

// File: rtl/xfr_rst_sync.sv
module xfr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/xfr_cfg_regs.sv
module xfr_cfg_regs #(
  parameter int unsigned DW         = 32,
  parameter int unsigned IW         = 6,
  parameter logic [31:0] VERSION    = 32'h0400_0000,
  parameter logic [31:0] MASTER_ID  = 32'h0000_001F,
  parameter logic [31:0] FLUSH_MASK = 32'hFFFF_F000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IW-1:0]               idx,
  input  logic [DW-1:0]               wdata,
  output logic [(1<<IW)-1:0][DW-1:0]  regs_q
);
  import xfr_pkg::*;
  localparam int unsigned NREGS = 1 << IW;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == IDX_STAT || g == IDX_ADDR) begin : g_hole
      assign regs_q[g] = '0;
    end else begin : g_word
      localparam logic [DW-1:0] RST_VAL =
        (g == IDX_CTRL) ? DW'(VERSION) : (g == IDX_ARB) ? DW'(MASTER_ID) : '0;
      localparam logic [DW-1:0] KEEP =
        (g == IDX_FLUSH) ? DW'(FLUSH_MASK) : '1;
      logic          we;
      logic [DW-1:0] word_d;
      logic [DW-1:0] word_q;

      always_comb begin
        we     = wr_en && (idx == IW'(g));
        word_d = wdata & KEEP;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  word_q <= RST_VAL;
        else if (we) word_q <= word_d;
      end

      assign regs_q[g] = word_q;

      if (g == IDX_FLUSH) begin : g_chk
        p_flush_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
          we |=> (word_q == ($past(wdata) & DW'(FLUSH_MASK))));
      end
    end
  end
endmodule

// File: rtl/xfr_fault_capture.sv
module xfr_fault_capture #(
  parameter int unsigned DW        = 32,
  parameter logic [31:0] WR_MASK   = 32'h0000_00FF,
  parameter logic [31:0] RESV_BITS = 32'h0000_0F00,
  parameter int unsigned RD_BIT    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_addr,
  input  logic          clr_req,
  input  logic [DW-1:0] wdata,
  input  logic          flt_valid,
  input  logic [DW-1:0] flt_addr,
  input  logic          flt_is_read,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] addr_q,
  output logic          irq_q
);
  localparam logic [DW-1:0] RESV   = DW'(RESV_BITS);
  localparam logic [DW-1:0] WMASK  = DW'(WR_MASK);
  localparam logic [DW-1:0] RD_ONE = DW'(1) << RD_BIT;

  logic [DW-1:0] stat_d;
  logic [DW-1:0] addr_d;
  logic          irq_d;
  logic          stat_en;
  logic          addr_en;

  always_comb begin
    stat_d = wr_stat ? ((wdata & WMASK) | RESV) : stat_q;
    if (flt_valid && flt_is_read) stat_d = stat_d | RD_ONE;
    stat_en = wr_stat || (flt_valid && flt_is_read);

    addr_d  = flt_valid ? flt_addr : wdata;
    addr_en = flt_valid || wr_addr;

    if (flt_valid)    irq_d = 1'b1;
    else if (clr_req) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= RESV;
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (addr_en) addr_q <= addr_d;
      irq_q <= irq_d;
    end
  end

  p_resv_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & RESV) == RESV);
  p_fault_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (addr_q == $past(flt_addr)));
  p_fault_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> irq_q);
  p_rd_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_is_read) |=> stat_q[RD_BIT]);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !flt_valid) |=> !irq_q);
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !flt_valid) |=> $stable(irq_q));
endmodule

// File: rtl/xlat_fault_regs.sv
module xlat_fault_regs #(
  parameter int unsigned DW         = 32,
  parameter int unsigned IW         = 6,
  parameter logic [31:0] VERSION    = 32'h0400_0000,
  parameter logic [31:0] MASTER_ID  = 32'h0000_001F,
  parameter logic [31:0] WR_MASK    = 32'h0000_00FF,
  parameter logic [31:0] RESV_BITS  = 32'h0000_0F00,
  parameter logic [31:0] FLUSH_MASK = 32'hFFFF_F000,
  parameter int unsigned RD_BIT     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          flt_valid,
  input  logic [DW-1:0] flt_addr,
  input  logic          flt_is_read,
  output logic          err_irq
);
  import xfr_pkg::*;
  localparam int unsigned NREGS = 1 << IW;

  logic                        rst_s;
  logic [NREGS-1:0][DW-1:0]    regs_q;
  logic [DW-1:0]               stat_q;
  logic [DW-1:0]               addr_q;
  logic                        hit_stat;
  logic                        hit_addr;
  logic                        clr_req;
  logic [DW-1:0]               rd_sel;
  logic [DW-1:0]               rdata_d;
  logic [DW-1:0]               rdata_q;

  xfr_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  xfr_cfg_regs #(
    .DW(DW), .IW(IW), .VERSION(VERSION), .MASTER_ID(MASTER_ID),
    .FLUSH_MASK(FLUSH_MASK)
  ) i_cfg (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_en  (wr_en),
    .idx    (idx),
    .wdata  (wdata),
    .regs_q (regs_q)
  );

  always_comb begin
    hit_stat = (idx == IW'(IDX_STAT));
    hit_addr = (idx == IW'(IDX_ADDR));
    clr_req  = (rd_en || wr_en) && (hit_stat || hit_addr);
  end

  xfr_fault_capture #(
    .DW(DW), .WR_MASK(WR_MASK), .RESV_BITS(RESV_BITS), .RD_BIT(RD_BIT)
  ) i_fault (
    .clk         (clk),
    .rst_n       (rst_s),
    .wr_stat     (wr_en && hit_stat),
    .wr_addr     (wr_en && hit_addr),
    .clr_req     (clr_req),
    .wdata       (wdata),
    .flt_valid   (flt_valid),
    .flt_addr    (flt_addr),
    .flt_is_read (flt_is_read),
    .stat_q      (stat_q),
    .addr_q      (addr_q),
    .irq_q       (err_irq)
  );

  always_comb begin
    if (hit_stat)      rd_sel = stat_q;
    else if (hit_addr) rd_sel = addr_q;
    else               rd_sel = regs_q[idx];
    rdata_d = rd_en ? rd_sel : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_en |=> $stable(rdata_q));
  p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && (hit_stat || hit_addr) && !flt_valid) |=> !err_irq);
endmodule

// File: tb/test_xlat_fault_regs.sv
module test_xlat_fault_regs;
  localparam logic [31:0] VER  = 32'h0400_0000;
  localparam logic [31:0] MID  = 32'h0000_001F;
  localparam logic [31:0] WM   = 32'h0000_00FF;
  localparam logic [31:0] RESV = 32'h0000_0F00;
  localparam logic [31:0] FM   = 32'hFFFF_F000;
  localparam int          RDB  = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en, flt_valid, flt_is_read;
  logic [5:0]  idx;
  logic [31:0] wdata, flt_addr, rdata;
  logic        err_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_regs [64];
  logic [31:0] m_rdata;
  logic        m_irq;

  always #4 clk = ~clk;

  xlat_fault_regs i_xlat_fault_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .idx(idx),
    .wdata(wdata), .rdata(rdata), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_is_read(flt_is_read), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit rd, input bit wr, input logic [5:0] ix,
                     input logic [31:0] wd, input bit fv, input logic [31:0] fa, input bit fr);
    bit clr;
    rd_en = rd; wr_en = wr; idx = ix; wdata = wd;
    flt_valid = fv; flt_addr = fa; flt_is_read = fr;
    if (rd) m_rdata = m_regs[ix];
    clr = (rd || wr) && (ix == 3 || ix == 4);
    if (wr) begin
      if (ix == 2)      m_regs[ix] = wd & FM;
      else if (ix == 3) m_regs[ix] = (wd & WM) | RESV;
      else              m_regs[ix] = wd;
    end
    if (fv) begin
      m_regs[4] = fa;
      if (fr) m_regs[3][RDB] = 1'b1;
    end
    if (fv)       m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rdata"}, rdata, m_rdata);
    chk({tag, " irq"}, {31'd0, err_irq}, {31'd0, m_irq});
    rd_en = 0; wr_en = 0; flt_valid = 0; flt_is_read = 0;
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 6'd0, 32'd0, 0, 32'd0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rd_en = 0; wr_en = 0; idx = 0; wdata = 0;
    flt_valid = 0; flt_addr = 0; flt_is_read = 0;
    for (int i = 0; i < 64; i++) m_regs[i] = 32'd0;
    m_regs[0] = VER; m_regs[1] = MID; m_regs[3] = RESV;
    m_rdata = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'd0);
    chk("R1 irq in reset", {31'd0, err_irq}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset values
    cyc("R1 ctrl", 1, 0, 6'd0, 0, 0, 0, 0);
    cyc("R1 arb", 1, 0, 6'd1, 0, 0, 0, 0);
    cyc("R1 status", 1, 0, 6'd3, 0, 0, 0, 0);
    cyc("R1 addr", 1, 0, 6'd4, 0, 0, 0, 0);
    // R2 plain storage
    cyc("R2 wr63", 0, 1, 6'd63, 32'hDEAD_BEEF, 0, 0, 0);
    cyc("R2 rd63", 1, 0, 6'd63, 0, 0, 0, 0);
    idle("R2 hold");
    cyc("R2 wr ctrl", 0, 1, 6'd0, 32'h1234_5678, 0, 0, 0);
    cyc("R2 rd+wr same", 1, 1, 6'd0, 32'hCAFE_0000, 0, 0, 0);
    cyc("R2 rd ctrl", 1, 0, 6'd0, 0, 0, 0, 0);
    // R3 flush mask
    cyc("R3 wr flush", 0, 1, 6'd2, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R3 rd flush", 1, 0, 6'd2, 0, 0, 0, 0);
    // R4 status masking
    cyc("R4 wr ones", 0, 1, 6'd3, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R4 rd", 1, 0, 6'd3, 0, 0, 0, 0);
    cyc("R4 wr zero", 0, 1, 6'd3, 32'h0000_0000, 0, 0, 0);
    cyc("R4 rd zero", 1, 0, 6'd3, 0, 0, 0, 0);
    // R5/R6 read fault, R7 clear by read
    cyc("R5 R6 read fault", 0, 0, 6'd0, 0, 1, 32'hA000_1234, 1);
    idle("R10 idle keeps irq");
    cyc("R10 other access", 1, 1, 6'd9, 32'h55, 0, 0, 0);
    cyc("R7 rd addr", 1, 0, 6'd4, 0, 0, 0, 0);
    cyc("R6 rd status", 1, 0, 6'd3, 0, 0, 0, 0);
    // R6 write fault keeps bit clear, then keeps it set
    cyc("R6 clear bit", 0, 1, 6'd3, 32'h0, 0, 0, 0);
    cyc("R6 write fault", 0, 0, 6'd0, 0, 1, 32'hB000_0040, 0);
    cyc("R7 R6 rd status", 1, 0, 6'd3, 0, 0, 0, 0);
    cyc("R6 read fault again", 0, 0, 6'd0, 0, 1, 32'hB000_0080, 1);
    cyc("R6 write fault keeps", 0, 0, 6'd0, 0, 1, 32'hB000_00C0, 0);
    cyc("R8 wr addr clears", 0, 1, 6'd4, 32'h7777_0000, 0, 0, 0);
    cyc("R8 rd addr", 1, 0, 6'd4, 0, 0, 0, 0);
    // R9 collisions
    cyc("R9 fault vs rd addr", 1, 0, 6'd4, 0, 1, 32'hC000_0001, 0);
    cyc("R9 fault vs wr status", 0, 1, 6'd3, 32'h0, 1, 32'hC000_0002, 1);
    cyc("R5 R9 fault vs wr addr", 0, 1, 6'd4, 32'h1111_1111, 1, 32'hC000_0003, 0);
    cyc("R5 rd addr", 1, 0, 6'd4, 0, 0, 0, 0);
    cyc("R6 rd status", 1, 0, 6'd3, 0, 0, 0, 0);
    cyc("R8 wr status clears", 0, 1, 6'd3, 32'h3C, 0, 0, 0);

    // random mix covering R2..R10
    for (int n = 0; n < 1500; n++) begin
      logic [5:0] ix;
      ix = ($urandom % 4 != 0) ? 6'($urandom % 8) : 6'($urandom);
      cyc("R2-mix", 1'($urandom % 2), 1'($urandom % 3 == 0), ix, $urandom,
          1'($urandom % 5 == 0), $urandom, 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule